// File: doc/BRIEF.md
# Interleaved Vector Structure Access Sequencer

This block expands one multi-register vector structure load or store into an ordered stream of single-element memory accesses. A command gives the number of elements in each structure, the number of vector registers involved, an element size code, a flag selecting a full 128-bit or a half 64-bit register, the index of the first register and a byte base address. The block then presents one access per beat: the byte address, the access size, the vector register index and the lane inside that register.

The register file and the memory sit outside the block. For a load, the consumer writes the returned element into the named register lane. For a store, it reads that lane and writes it to memory. Structure forms (equal element and register counts) interleave the elements of each structure across consecutive registers. The one-element forms that span several registers instead fill each register completely before moving to the next. A one-cycle completion pulse closes each command. A command with an unsupported pairing of counts is rejected with an error pulse and produces no accesses.

Top module: `vstruct_seq`

## Requirements
- R1: After reset the block is idle: `cmd_ready`=1 and `acc_valid`, `seq_done` and `cmd_err` are all 0.
- R2: Size code s (0..3) selects an element of 8<<s bits and `acc_size` equals s. The first access is at `cmd_base`, and each following access is 1<<s bytes above the previous one, so addresses are contiguous.
- R3: A register holds (8>>s) lanes when `cmd_full`=0 and twice that when `cmd_full`=1. `acc_lane` counts from 0 up to that number minus 1.
- R4: With N=`cmd_elems` and M=`cmd_regs`, the repeat count R is 1 when N equals M and M otherwise. A command issues exactly R x lanes x N accesses.
- R5: Accesses follow the nested order repeat index i (outermost), lane j, then element k (innermost). Each access carries `acc_lane`=j and register `cmd_first_reg`+i+k.
- R6: Register indices wrap modulo 32, so a sequence that passes register 31 continues at register 0.
- R7: A store (`cmd_store`=1) follows the same order as a load, with `acc_write`=1 on every access. A load has `acc_write`=0.
- R8: Only the pairs (1,1), (2,2), (3,3), (4,4), (1,2), (1,3) and (1,4) are accepted. Any other pair raises `cmd_err` for one cycle, the cycle after acceptance. It issues no access and leaves the block idle.
- R9: While `acc_valid`=1 and `acc_ready`=0, the address, register, lane, size and direction are held unchanged.
- R10: The cycle after the final access is taken, `seq_done` is high for exactly one cycle with `acc_valid`=0. On the cycle after that, `cmd_ready` is 1 again.
- R11: A command offered while the block is busy (`cmd_ready`=0) is ignored. It does not disturb the running sequence and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_elems | input | 3 | Elements per structure (N) |
| cmd_regs | input | 3 | Registers involved (M) |
| cmd_size | input | 2 | Element size code |
| cmd_full | input | 1 | 1 = 128-bit registers, 0 = 64-bit |
| cmd_first_reg | input | 5 | First vector register index |
| cmd_base | input | ADDR_W | Byte base address |
| cmd_err | output | 1 | One-cycle pulse: unsupported count pair |
| acc_valid | output | 1 | An access is presented |
| acc_ready | input | 1 | Memory takes the presented access |
| acc_write | output | 1 | Access is a memory write (store) |
| acc_size | output | 2 | Access size code |
| acc_addr | output | ADDR_W | Access byte address |
| acc_reg | output | 5 | Vector register index |
| acc_lane | output | 4 | Lane index inside the register |
| seq_done | output | 1 | One-cycle pulse after the last access |

## Verification
The main function is swept over every legal count pair, all four sizes and both register widths. Each sweep runs from a low first register and again from one near the top of the register file. Equal pairs against one-element multi-register pairs separate the interleaved order from the register-by-register order, the size sweep separates address stride from lane count, and the high start register exposes any missing modulo-32 wrap. Random back-pressure on `acc_ready` tells a design that holds its access from one that advances early. Illegal pairs, and commands offered during a running sequence, show whether rejection and busy-ignore leave the access stream untouched.

// File: rtl/vstruct_pkg.sv
package vstruct_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_DONE = 2'd2
  } seq_state_t;

endpackage

// File: rtl/vstruct_decode.sv
// Legality check and loop limits for one command.
module vstruct_decode #(
  parameter int MAX_STRUCT = 4,
  parameter int VREG_BITS  = 128,
  parameter int STR_W      = 3,
  parameter int LANE_W     = 4
) (
  input  logic [STR_W-1:0]  elems,
  input  logic [STR_W-1:0]  regs,
  input  logic [1:0]        size,
  input  logic              full,
  output logic              legal,
  output logic [STR_W-1:0]  rpt_m1,
  output logic [STR_W-1:0]  selem_m1,
  output logic [LANE_W-1:0] lanes_m1
);
  localparam int HALF_LANES = VREG_BITS / 16;

  logic              in_range;
  logic [LANE_W:0]   lane_cnt;

  always_comb begin
    in_range = (elems != '0) && (regs != '0) &&
               (int'(elems) <= MAX_STRUCT) && (int'(regs) <= MAX_STRUCT);
    legal    = in_range && ((elems == regs) || (elems == STR_W'(1)));
    selem_m1 = elems - STR_W'(1);
    rpt_m1   = (elems == regs) ? '0 : (regs - STR_W'(1));
    lane_cnt = (LANE_W+1)'(HALF_LANES) >> size;
    if (full) lane_cnt = lane_cnt << 1;
    lanes_m1 = LANE_W'(lane_cnt - (LANE_W+1)'(1));
  end

endmodule

// File: rtl/vstruct_nest_ctr.sv
// Three nested counters: repeat (outer), lane, element (inner).
module vstruct_nest_ctr #(
  parameter int STR_W  = 3,
  parameter int LANE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [STR_W-1:0]  rpt_m1,
  input  logic [STR_W-1:0]  selem_m1,
  input  logic [LANE_W-1:0] lanes_m1,
  output logic [STR_W-1:0]  i_nxt,
  output logic [LANE_W-1:0] j_nxt,
  output logic [STR_W-1:0]  k_nxt,
  output logic              last
);
  logic [STR_W-1:0]  i_q, k_q, rpt_q, selem_q;
  logic [LANE_W-1:0] j_q, lanes_q;

  always_comb begin
    i_nxt = i_q;
    j_nxt = j_q;
    k_nxt = k_q;
    if (k_q == selem_q) begin
      k_nxt = '0;
      if (j_q == lanes_q) begin
        j_nxt = '0;
        i_nxt = i_q + STR_W'(1);
      end else begin
        j_nxt = j_q + LANE_W'(1);
      end
    end else begin
      k_nxt = k_q + STR_W'(1);
    end
    last = (k_q == selem_q) && (j_q == lanes_q) && (i_q == rpt_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      i_q     <= '0;
      j_q     <= '0;
      k_q     <= '0;
      rpt_q   <= '0;
      selem_q <= '0;
      lanes_q <= '0;
    end else if (load) begin
      i_q     <= '0;
      j_q     <= '0;
      k_q     <= '0;
      rpt_q   <= rpt_m1;
      selem_q <= selem_m1;
      lanes_q <= lanes_m1;
    end else if (step) begin
      i_q <= i_nxt;
      j_q <= j_nxt;
      k_q <= k_nxt;
    end
  end

  // R4
  ctr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (i_q <= rpt_q) && (j_q <= lanes_q) && (k_q <= selem_q));

  // R4
  no_step_past_end_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |-> !last);

endmodule

// File: rtl/vstruct_beat_gen.sv
// Registered per-beat address, register index and lane.
module vstruct_beat_gen #(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 5,
  parameter int STR_W  = 3,
  parameter int LANE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  input  logic [REG_W-1:0]  first_reg,
  input  logic [1:0]        size,
  input  logic [STR_W-1:0]  i_nxt,
  input  logic [LANE_W-1:0] j_nxt,
  input  logic [STR_W-1:0]  k_nxt,
  output logic [ADDR_W-1:0] addr,
  output logic [REG_W-1:0]  vreg,
  output logic [LANE_W-1:0] lane,
  output logic [1:0]        size_q
);
  logic [REG_W-1:0]  first_q;
  logic [ADDR_W-1:0] stride;

  assign stride = ADDR_W'(1) << size_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr    <= '0;
      vreg    <= '0;
      lane    <= '0;
      size_q  <= '0;
      first_q <= '0;
    end else if (load) begin
      addr    <= base;
      vreg    <= first_reg;
      lane    <= '0;
      size_q  <= size;
      first_q <= first_reg;
    end else if (step) begin
      addr <= addr + stride;
      vreg <= first_q + REG_W'(i_nxt) + REG_W'(k_nxt);
      lane <= j_nxt;
    end
  end

  // R2
  load_start_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (addr == $past(base)) && (lane == '0) && (vreg == $past(first_reg)));

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(addr) && $stable(vreg) && $stable(lane));

endmodule

// File: rtl/vstruct_seq.sv
// Top: command intake, run control and access stream outputs.
module vstruct_seq
  import vstruct_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_VREGS  = 32,
  parameter int VREG_BITS  = 128,
  parameter int MAX_STRUCT = 4,
  localparam int REG_W     = $clog2(NUM_VREGS),
  localparam int STR_W     = $clog2(MAX_STRUCT + 1),
  localparam int LANE_W    = $clog2(VREG_BITS / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_store,
  input  logic [STR_W-1:0]  cmd_elems,
  input  logic [STR_W-1:0]  cmd_regs,
  input  logic [1:0]        cmd_size,
  input  logic              cmd_full,
  input  logic [REG_W-1:0]  cmd_first_reg,
  input  logic [ADDR_W-1:0] cmd_base,
  output logic              cmd_err,
  output logic              acc_valid,
  input  logic              acc_ready,
  output logic              acc_write,
  output logic [1:0]        acc_size,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [REG_W-1:0]  acc_reg,
  output logic [LANE_W-1:0] acc_lane,
  output logic              seq_done
);
  seq_state_t        state_q;
  logic              legal, accept, load, fire, step, last;
  logic              err_q, write_q;
  logic [STR_W-1:0]  rpt_m1, selem_m1, i_nxt, k_nxt;
  logic [LANE_W-1:0] lanes_m1, j_nxt;

  vstruct_decode #(
    .MAX_STRUCT(MAX_STRUCT), .VREG_BITS(VREG_BITS), .STR_W(STR_W), .LANE_W(LANE_W)
  ) u_decode (
    .elems(cmd_elems), .regs(cmd_regs), .size(cmd_size), .full(cmd_full),
    .legal(legal), .rpt_m1(rpt_m1), .selem_m1(selem_m1), .lanes_m1(lanes_m1)
  );

  vstruct_nest_ctr #(.STR_W(STR_W), .LANE_W(LANE_W)) u_ctr (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .rpt_m1(rpt_m1), .selem_m1(selem_m1), .lanes_m1(lanes_m1),
    .i_nxt(i_nxt), .j_nxt(j_nxt), .k_nxt(k_nxt), .last(last)
  );

  vstruct_beat_gen #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .STR_W(STR_W), .LANE_W(LANE_W)
  ) u_beat (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .base(cmd_base), .first_reg(cmd_first_reg), .size(cmd_size),
    .i_nxt(i_nxt), .j_nxt(j_nxt), .k_nxt(k_nxt),
    .addr(acc_addr), .vreg(acc_reg), .lane(acc_lane), .size_q(acc_size)
  );

  assign cmd_ready = (state_q == SQ_IDLE);
  assign acc_valid = (state_q == SQ_RUN);
  assign seq_done  = (state_q == SQ_DONE);
  assign cmd_err   = err_q;
  assign acc_write = write_q;

  assign accept = cmd_valid && cmd_ready;
  assign load   = accept && legal;
  assign fire   = acc_valid && acc_ready;
  assign step   = fire && !last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      err_q   <= 1'b0;
      write_q <= 1'b0;
    end else begin
      err_q <= accept && !legal;
      unique case (state_q)
        SQ_IDLE: if (load) begin
          state_q <= SQ_RUN;
          write_q <= cmd_store;
        end
        SQ_RUN:  if (fire && last) state_q <= SQ_DONE;
        SQ_DONE: state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // R2
  addr_contig_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> !acc_valid || (acc_addr == $past(acc_addr) + (ADDR_W'(1) << acc_size)));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_ready) |=> acc_valid && $stable(acc_addr) && $stable(acc_reg)
      && $stable(acc_lane) && $stable(acc_size) && $stable(acc_write));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !seq_done && cmd_ready);

  // R10
  done_follows_fire_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_done) |-> $past(fire) && !acc_valid);

  // R8
  err_no_access_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> !acc_valid && cmd_ready && !$past(acc_valid));

  // R11
  busy_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_ready |=> !cmd_err);

  // R1
  state_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_ready, acc_valid, seq_done}) && (cmd_ready || acc_valid || seq_done));

endmodule

// File: tb/test_vstruct_seq.sv
module test_vstruct_seq;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic              cmd_store = 1'b0;
  logic [2:0]        cmd_elems = 3'd1;
  logic [2:0]        cmd_regs = 3'd1;
  logic [1:0]        cmd_size = 2'd0;
  logic              cmd_full = 1'b0;
  logic [4:0]        cmd_first_reg = 5'd0;
  logic [ADDR_W-1:0] cmd_base = '0;
  logic              cmd_err;
  logic              acc_valid;
  logic              acc_ready = 1'b0;
  logic              acc_write;
  logic [1:0]        acc_size;
  logic [ADDR_W-1:0] acc_addr;
  logic [4:0]        acc_reg;
  logic [3:0]        acc_lane;
  logic              seq_done;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vstruct_seq #(.ADDR_W(ADDR_W)) i_vstruct_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_store(cmd_store), .cmd_elems(cmd_elems), .cmd_regs(cmd_regs),
    .cmd_size(cmd_size), .cmd_full(cmd_full), .cmd_first_reg(cmd_first_reg),
    .cmd_base(cmd_base), .cmd_err(cmd_err), .acc_valid(acc_valid),
    .acc_ready(acc_ready), .acc_write(acc_write), .acc_size(acc_size),
    .acc_addr(acc_addr), .acc_reg(acc_reg), .acc_lane(acc_lane),
    .seq_done(seq_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // Run one legal command; noise=1 keeps offering an illegal command while busy.
  task automatic run_cmd(input int n, input int m, input int sz, input bit full,
                         input int first, input logic [ADDR_W-1:0] base,
                         input bit store, input bit noise, input int stall_pct);
    int rpt, lanes, beat;
    rpt   = (n == m) ? 1 : m;
    lanes = (8 >> sz) << full;
    beat  = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_elems = 3'(n); cmd_regs = 3'(m); cmd_size = 2'(sz);
    cmd_full = full; cmd_first_reg = 5'(first); cmd_base = base; cmd_store = store;
    @(negedge clk);
    if (noise) begin
      cmd_elems = 3'd3; cmd_regs = 3'd2; cmd_base = ~base;
    end else begin
      cmd_valid = 1'b0;
    end
    for (int i = 0; i < rpt; i++)
      for (int j = 0; j < lanes; j++)
        for (int k = 0; k < n; k++) begin
          logic [ADDR_W-1:0] ea;
          logic [4:0] er;
          bit taken;
          ea = base + ADDR_W'(beat << sz);
          er = 5'(first + i + k);
          taken = 0;
          while (!taken) begin
            chk(acc_valid === 1'b1, "R4", "acc_valid during beat", acc_valid, 1);
            chk(acc_addr === ea, "R2", "address", acc_addr, ea);
            chk(acc_size === 2'(sz), "R2", "size code", acc_size, sz);
            chk(acc_lane === 4'(j), "R3", "lane", acc_lane, j);
            chk(acc_reg === er, (first + i + k > 31) ? "R6" : "R5", "register", acc_reg, er);
            chk(acc_write === store, "R7", "direction", acc_write, store);
            chk(cmd_err === 1'b0, "R11", "no error while busy", cmd_err, 0);
            taken = (($urandom % 100) >= stall_pct);
            acc_ready = taken;
            @(negedge clk);
            // R9: a stalled beat must be presented again unchanged
          end
          beat++;
        end
    acc_ready = 1'b0;
    cmd_valid = 1'b0;
    chk(seq_done === 1'b1, "R10", "done pulse", seq_done, 1);
    chk(acc_valid === 1'b0, "R4", "no extra access", acc_valid, 0);
    chk(cmd_ready === 1'b0, "R10", "busy in done cycle", cmd_ready, 0);
    @(negedge clk);
    chk(seq_done === 1'b0, "R10", "done one cycle", seq_done, 0);
    chk(cmd_ready === 1'b1, "R10", "idle again", cmd_ready, 1);
    chk(cmd_err === 1'b0, "R11", "busy command ignored", cmd_err, 0);
  endtask

  task automatic run_bad(input int n, input int m);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_elems = 3'(n); cmd_regs = 3'(m);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_err === 1'b1, "R8", "error pulse", cmd_err, 1);
    chk(acc_valid === 1'b0, "R8", "no access", acc_valid, 0);
    chk(cmd_ready === 1'b1, "R8", "stays idle", cmd_ready, 1);
    @(negedge clk);
    chk(cmd_err === 1'b0, "R8", "error one cycle", cmd_err, 0);
    chk(acc_valid === 1'b0 && seq_done === 1'b0, "R8", "still no access",
        {acc_valid, seq_done}, 0);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        mismatched++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        summary();
      end
    end
  end

  initial begin
    int n_tab [7] = '{1, 2, 3, 4, 1, 1, 1};
    int m_tab [7] = '{1, 2, 3, 4, 2, 3, 4};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(cmd_ready === 1'b1, "R1", "reset cmd_ready", cmd_ready, 1);
    chk(acc_valid === 1'b0, "R1", "reset acc_valid", acc_valid, 0);
    chk(seq_done === 1'b0, "R1", "reset seq_done", seq_done, 0);
    chk(cmd_err === 1'b0, "R1", "reset cmd_err", cmd_err, 0);

    for (int p = 0; p < 7; p++)
      for (int sz = 0; sz < 4; sz++)
        for (int f = 0; f < 2; f++) begin
          run_cmd(n_tab[p], m_tab[p], sz, f[0], p * 3, 32'h1000 + 32'(p * 256),
                  (p + sz) % 2 == 1, 1'b0, 30);
          run_cmd(n_tab[p], m_tab[p], sz, f[0], 29 + sz, 32'hFFFF_FFF0,
                  (p + sz + f) % 2 == 0, (sz == 2), 0);
        end

    run_bad(0, 0);
    run_bad(2, 3);
    run_bad(3, 1);
    run_bad(5, 5);
    run_bad(4, 2);
    run_bad(1, 5);

    run_cmd(4, 4, 0, 1'b1, 31, 32'h0000_0100, 1'b1, 1'b1, 60);
    run_cmd(1, 4, 3, 1'b1, 31, 32'h0000_2000, 1'b0, 1'b0, 0);

    finished = 1;
    summary();
  end
endmodule